// File: doc/BRIEF.md
# Vector Pattern Generator with Bit Replication

This block supplies one data bit per pixel write while lines are drawn one pixel at a time. A processor loads an 8-bit dash pattern and a 4-bit stretch value. The pattern rotates toward its low end, and the output is always its lowest bit, so the pattern is emitted low bit first and wraps around without end. Each pattern bit stays on the output for a number of write cycles set by the stretch value, so one stored pattern can give short dashes or long ones.

A write-cycle strobe advances the generator by one cycle. Two load strobes share one 8-bit data bus: one load strobe writes the stretch value, and the other writes the pattern. Software loads the stretch value first and the pattern second. The pattern load restarts the hold count, so the first bit of the new pattern gets its full hold time. The output bit feeds the plane write logic, which lies outside this block.

Top module: `vector_pattern_gen`

## Requirements
- R1: After reset, `bit_out` is 0, the stretch value is 0 and the hold count is cleared. With no stretch load after reset, each bit is held for 16 write cycles.
- R2: A cycle with `pat_load` high stores `load_data[7:0]` as the pattern. In the next cycle `bit_out` equals `load_data[0]`, and the hold count restarts from zero.
- R3: With stretch value M, taken from `load_data[3:0]` on a cycle with `mult_load` high, the pattern rotates by one place after exactly 16−M write cycles. The output then moves to the next higher pattern bit.
- R4: Pattern bits appear in order 0, 1, …, 7. After bit 7 has been held, bit 0 appears again, so 8·(16−M) write cycles bring the output back to the start.
- R5: A stretch value of 15 advances on every write cycle. A value of 12 holds each bit for 4 cycles, a value of 5 for 11 cycles, and a value of 0 for 16 cycles.
- R6: A stretch load changes neither the pattern nor `bit_out`, and it does not clear the hold count. The new hold length applies from the next write cycle. If the count already reached or passed the new limit, that next write cycle rotates the pattern.
- R7: A cycle with `wr_cycle` low and `pat_load` low leaves `bit_out` unchanged.
- R8: When `pat_load` and `wr_cycle` are high in the same cycle, the load takes priority. That write cycle is ignored and does not count toward the hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_cycle | input | 1 | One pulse per pixel write cycle |
| mult_load | input | 1 | Store `load_data[3:0]` as the stretch value |
| pat_load | input | 1 | Store `load_data` as the pattern and restart the hold count |
| load_data | input | 8 | Shared load data bus |
| bit_out | output | 1 | Current pattern bit, the lowest bit of the pattern |

## Verification
The bound checker keeps its own model of the pattern, the stretch value and the hold count, and compares `bit_out` with that model on every cycle. It also checks on every cycle that an idle cycle or a stretch load leaves the output alone, and that a pattern load shows the new lowest bit one cycle later. The exact hold lengths for each stretch value, the wrap after bit 7, a stretch change partway through a hold, and the priority of a load over a write in the same cycle are shown only by the bench's directed scenarios. Those scenarios compare the output against values worked out by hand from the requirements.

// File: rtl/vpg_pkg.sv
package vpg_pkg;
    // Default geometry: 8-bit dash pattern, 4-bit stretch value
    localparam int unsigned VPG_PAT_W  = 8;
    localparam int unsigned VPG_MULT_W = 4;
endpackage

// File: rtl/vpg_hold_counter.sv
module vpg_hold_counter #(
    parameter int unsigned MULT_W = vpg_pkg::VPG_MULT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              restart,
    input  logic              mult_load,
    input  logic [MULT_W-1:0] mult_data,
    output logic              advance
);
    localparam int unsigned CNT_W = MULT_W + 1;
    localparam logic [CNT_W-1:0] SPAN = CNT_W'(1) << MULT_W;

    typedef struct packed {
        logic [MULT_W-1:0] mult;
        logic [CNT_W-1:0]  cnt;
    } hold_state_t;

    hold_state_t s_d, s_q;
    logic [CNT_W-1:0] hold_len;

    always_comb begin
        s_d      = s_q;
        // Hold length is 2**MULT_W minus the stretch value; zero gives the full span
        hold_len = SPAN - CNT_W'(s_q.mult);
        advance  = step && !restart && (s_q.cnt >= hold_len - CNT_W'(1));
        if (mult_load) begin
            s_d.mult = mult_data;
        end
        if (restart) begin
            s_d.cnt = '0;
        end else if (step) begin
            s_d.cnt = advance ? '0 : s_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/vpg_pattern_ring.sv
module vpg_pattern_ring #(
    parameter int unsigned PAT_W = vpg_pkg::VPG_PAT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PAT_W-1:0] load_value,
    input  logic             advance,
    output logic             lsb
);
    typedef struct packed {
        logic [PAT_W-1:0] pat;
    } ring_state_t;

    ring_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.pat = load_value;
        end else if (advance) begin
            // Rotate toward the low end; bit 0 wraps into the top
            s_d.pat = {s_q.pat[0], s_q.pat[PAT_W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign lsb = s_q.pat[0];
endmodule

// File: rtl/vector_pattern_gen.sv
module vector_pattern_gen #(
    parameter int unsigned PAT_W  = vpg_pkg::VPG_PAT_W,
    parameter int unsigned MULT_W = vpg_pkg::VPG_MULT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_cycle,
    input  logic             mult_load,
    input  logic             pat_load,
    input  logic [PAT_W-1:0] load_data,
    output logic             bit_out
);
    logic advance;

    vpg_hold_counter #(.MULT_W(MULT_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (wr_cycle),
        .restart   (pat_load),
        .mult_load (mult_load),
        .mult_data (load_data[MULT_W-1:0]),
        .advance   (advance)
    );

    vpg_pattern_ring #(.PAT_W(PAT_W)) u_ring (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (pat_load),
        .load_value (load_data),
        .advance    (advance),
        .lsb        (bit_out)
    );
endmodule

// File: rtl/vpg_checker.sv
module vpg_checker #(
    parameter int unsigned PAT_W  = 8,
    parameter int unsigned MULT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_cycle,
    input logic             mult_load,
    input logic             pat_load,
    input logic [PAT_W-1:0] load_data,
    input logic             bit_out
);
    localparam int unsigned CNT_W = MULT_W + 1;

    // Independent reference model, written from the requirements
    logic [PAT_W-1:0]  ref_pat;
    logic [MULT_W-1:0] ref_mult;
    logic [CNT_W-1:0]  ref_runs;
    logic [CNT_W-1:0]  ref_limit;

    assign ref_limit = CNT_W'(16) - CNT_W'(ref_mult);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_pat  <= '0;
            ref_mult <= '0;
            ref_runs <= '0;
        end else begin
            if (mult_load) ref_mult <= load_data[MULT_W-1:0];
            if (pat_load) begin
                ref_pat  <= load_data;
                ref_runs <= '0;
            end else if (wr_cycle) begin
                if (ref_runs + CNT_W'(1) >= ref_limit) begin
                    ref_runs <= '0;
                    ref_pat  <= {ref_pat[0], ref_pat[PAT_W-1:1]};
                end else begin
                    ref_runs <= ref_runs + CNT_W'(1);
                end
            end
        end
    end

    // R3 R4 R5: output follows the reference rotation
    p_model_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_out == ref_pat[0]);

    p_load_lsb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pat_load |=> bit_out == $past(load_data[0]));

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_cycle && !pat_load) |=> $stable(bit_out));

    p_mult_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mult_load && !wr_cycle && !pat_load) |=> $stable(bit_out));
endmodule

bind vector_pattern_gen vpg_checker #(.PAT_W(PAT_W), .MULT_W(MULT_W)) u_chk (.*);

// File: tb/sim_vector_pattern_gen.sv
module sim_vector_pattern_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_cycle = 1'b0;
    logic       mult_load = 1'b0;
    logic       pat_load = 1'b0;
    logic [7:0] load_data = '0;
    logic       bit_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    vector_pattern_gen u0 (.*);

    always #4 clk = ~clk;

    typedef struct packed {
        logic [3:0] m;
        logic [7:0] p;
        logic [7:0] n;
        logic       e;
    } vec_t;

    // mult, pattern, write cycles after load, expected bit
    localparam vec_t VEC [0:15] = '{
        '{4'd15, 8'hA6, 8'd0,   1'b0},
        '{4'd15, 8'hA6, 8'd1,   1'b1},
        '{4'd15, 8'hA6, 8'd2,   1'b1},
        '{4'd15, 8'hA6, 8'd3,   1'b0},
        '{4'd15, 8'hA6, 8'd7,   1'b1},
        '{4'd15, 8'hA6, 8'd8,   1'b0},
        '{4'd12, 8'h01, 8'd3,   1'b1},
        '{4'd12, 8'h01, 8'd4,   1'b0},
        '{4'd5,  8'h02, 8'd10,  1'b0},
        '{4'd5,  8'h02, 8'd11,  1'b1},
        '{4'd0,  8'h02, 8'd15,  1'b0},
        '{4'd0,  8'h02, 8'd16,  1'b1},
        '{4'd0,  8'h80, 8'd111, 1'b0},
        '{4'd0,  8'h80, 8'd112, 1'b1},
        '{4'd0,  8'h80, 8'd128, 1'b0},
        '{4'd12, 8'h33, 8'd8,   1'b0}
    };

    task automatic check(input logic exp, input string req);
        checks++;
        if (bit_out !== exp) begin
            fails++;
            $display("FAIL %s: bit_out=%b expected=%b", req, bit_out, exp);
        end
    endtask

    task automatic load_mult(input logic [3:0] m);
        load_data = {4'h0, m}; mult_load = 1'b1;
        @(negedge clk);
        mult_load = 1'b0;
    endtask

    task automatic load_pat(input logic [7:0] p, input logic with_wr);
        load_data = p; pat_load = 1'b1; wr_cycle = with_wr;
        @(negedge clk);
        pat_load = 1'b0; wr_cycle = 1'b0;
    endtask

    task automatic writes(input int n);
        for (int i = 0; i < n; i++) begin
            wr_cycle = 1'b1;
            @(negedge clk);
        end
        wr_cycle = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        checks++; fails++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_run();
    end

    initial begin
        @(negedge clk); @(negedge clk);
        check(1'b0, "R1 reset output");
        rst_n = 1'b1;
        @(negedge clk);
        check(1'b0, "R1 output after reset release");

        // R1: default stretch 0 gives a 16-cycle hold
        load_pat(8'h02, 1'b0);
        writes(15); check(1'b0, "R1 default hold 15");
        writes(1);  check(1'b1, "R1 default hold 16");

        // Table walk: R3 R4 R5 and R2
        for (int k = 0; k < 16; k++) begin
            load_mult(VEC[k].m);
            load_pat(VEC[k].p, 1'b0);
            if (VEC[k].n == 8'd0) check(VEC[k].p[0], "R2 load shows bit 0");
            writes(int'(VEC[k].n));
            check(VEC[k].e, $sformatf("R3/R4/R5 vector %0d", k));
        end

        // R7: idle cycles leave the output alone
        load_mult(4'd15);
        load_pat(8'h02, 1'b0);
        repeat (5) @(negedge clk);
        check(1'b0, "R7 idle no change");
        writes(1); check(1'b1, "R7 write after idle");

        // R6: a stretch load does not disturb the output
        load_pat(8'h02, 1'b0);
        load_mult(4'd12);
        check(1'b0, "R6 mult load no output change");
        writes(3); check(1'b0, "R6 new hold 3");
        writes(1); check(1'b1, "R6 new hold 4");

        // R6: shrinking hold mid-run shifts on the next write
        load_mult(4'd0);
        load_pat(8'h02, 1'b0);
        writes(10);
        load_mult(4'd12);
        check(1'b0, "R6 shrink no immediate change");
        writes(1); check(1'b1, "R6 shrink shifts on next write");

        // R8: load wins over a simultaneous write
        load_mult(4'd15);
        load_pat(8'h02, 1'b0);
        writes(1); check(1'b1, "R8 setup");
        load_pat(8'h01, 1'b1);
        check(1'b1, "R8 load wins over write");
        load_mult(4'd12);
        load_pat(8'h01, 1'b1);
        writes(3); check(1'b1, "R8 write in load cycle not counted");
        writes(1); check(1'b0, "R8 hold completes");

        // R2: reloading restarts the hold count
        load_pat(8'h01, 1'b0);
        writes(2);
        load_pat(8'h01, 1'b0);
        writes(3); check(1'b1, "R2 restart hold 3");
        writes(1); check(1'b0, "R2 restart hold 4");

        finish_run();
    end
endmodule